// File: doc/BRIEF.md
# Pad sleep-mode output controller

This block decides what each I/O pad drives while the chip sits in a low-power state. Two pad groups are handled: multiplexed pads and dedicated pads. Each group has its own bank of per-pad configuration, its own bank of write locks and its own bank of status words. Every pad carries four pieces of state:

- an arm bit;
- a two-bit sleep behaviour;
- a sticky status bit;
- a write-enable bit that can only be cleared.

When `sleep_req` is sampled high, every armed pad marks its status bit and captures its present functional output and output enable. From then on the pad drives its configured sleep value instead of the functional path. The override is not released on wake-up. It ends only when software clears that pad's status bit, after which the functional path drives the pad again.

Software reaches all state through a simple single-cycle register port. Writes take effect at the clock edge and reads return data combinationally. The address is `{group, region, index}`:

- `group` is the top bit: 0 selects the multiplexed pads and 1 the dedicated pads.
- `region` is the next two bits: 0 for the behaviour field, 1 for the arm bit, 2 for the write-enable bit and 3 for the status words.
- `index` is the low `IDX_W` bits. It is the pad number in regions 0 to 2 and the status word number in region 3.

Top module: `pad_sleep_ctrl`

## Requirements
- R1: After reset every pad reads behaviour 0, arm 0, write-enable 1 and status 0, and every pad output and output enable equal its functional inputs.
- R2: While a pad's status bit is set, it drives as follows:
  - behaviour 0: out=0, oe=1.
  - behaviour 1: out=1, oe=1.
  - behaviour 2: out=0, oe=0.
  - behaviour 3: out and oe equal the values captured when the status bit was set.
- R3: At a clock edge with `sleep_req` high, each armed pad sets its status bit. If that bit was clear before the edge, the pad also captures its functional out/oe at that edge. A pad whose status was already set keeps its earlier capture. Unarmed pads are unaffected. Writing 0 to the arm bit disarms the pad.
- R4: A status bit stays set after `sleep_req` falls. A pad's status bit sits in word pad/32 at bit pad%32. Writing a status word clears each bit that is written 0 and leaves each bit that is written 1 unchanged.
- R5: Once a pad's status bit is clear, its output and output enable follow the functional inputs again.
- R6: Writing a word with bit 0 at 0 to a pad's write-enable register clears that bit. Writing 1 never sets it again; only reset does.
- R7: While a pad's write-enable bit is 0, writes to its behaviour and arm registers are ignored, and reads keep returning the stored values.
- R8: A pad index at or beyond the group's pad count, or a status word index beyond the last word, reads zero and a write to it changes nothing.
- R9: The two groups hold separate state. The group bit selects which bank an access touches.
- R10: When a status-word write that clears a bit coincides with `sleep_req` on an armed pad, the pad's status bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep entry request, sampled at each clock edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+3 | {group, region[1:0], index} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mp_fn_out | input | NUM_MPADS | Functional output of multiplexed pads |
| mp_fn_oe | input | NUM_MPADS | Functional output enable of multiplexed pads |
| dp_fn_out | input | NUM_DPADS | Functional output of dedicated pads |
| dp_fn_oe | input | NUM_DPADS | Functional output enable of dedicated pads |
| mp_pad_out | output | NUM_MPADS | Output to multiplexed pads |
| mp_pad_oe | output | NUM_MPADS | Output enable to multiplexed pads |
| dp_pad_out | output | NUM_DPADS | Output to dedicated pads |
| dp_pad_oe | output | NUM_DPADS | Output enable to dedicated pads |

## Verification
The hardest situation to reach is a second sleep entry that finds some pads still held from the first one. Those pads must keep their original keep-mode capture, while newly armed pads capture the functional values present now. The bench reaches this state in three steps:

1. It enters sleep once with one functional pattern.
2. It clears only the even-numbered status bits through a mask word that spans both multiplexed status words.
3. It changes the functional pattern and enters sleep again.

A status clear issued in the same cycle as a sleep request is driven in the same way, and every step ends with a full sweep of all registers and pad outputs of both groups.

// File: rtl/pad_sleep_ctrl.sv
module pad_sleep_ctrl #(
  parameter int NUM_MPADS = 40,
  parameter int NUM_DPADS = 12,
  parameter int IDX_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep_req,
  input  logic                 reg_wr,
  input  logic [IDX_W+2:0]     reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_MPADS-1:0] mp_fn_out,
  input  logic [NUM_MPADS-1:0] mp_fn_oe,
  input  logic [NUM_DPADS-1:0] dp_fn_out,
  input  logic [NUM_DPADS-1:0] dp_fn_oe,
  output logic [NUM_MPADS-1:0] mp_pad_out,
  output logic [NUM_MPADS-1:0] mp_pad_oe,
  output logic [NUM_DPADS-1:0] dp_pad_out,
  output logic [NUM_DPADS-1:0] dp_pad_oe
);

  localparam logic [1:0] RG_MODE = 2'd0;
  localparam logic [1:0] RG_ARM  = 2'd1;
  localparam logic [1:0] RG_WEN  = 2'd2;
  localparam logic [1:0] RG_STAT = 2'd3;

  logic             grp;
  logic [1:0]       rg;
  logic [IDX_W-1:0] idx;
  logic             m_acc, d_acc;

  assign grp   = reg_addr[IDX_W+2];
  assign rg    = reg_addr[IDX_W+1:IDX_W];
  assign idx   = reg_addr[IDX_W-1:0];
  assign m_acc = reg_wr && !grp;
  assign d_acc = reg_wr && grp;

  logic [1:0]           m_mode [NUM_MPADS];
  logic [NUM_MPADS-1:0] m_en, m_wen, m_stat, m_lout, m_loe;
  logic [1:0]           d_mode [NUM_DPADS];
  logic [NUM_DPADS-1:0] d_en, d_wen, d_stat, d_lout, d_loe;

  function automatic logic [1:0] drive_of(input logic [1:0] md, input logic lo, input logic loe);
    case (md)
      2'd0:    drive_of = 2'b10;
      2'd1:    drive_of = 2'b11;
      2'd2:    drive_of = 2'b00;
      default: drive_of = {loe, lo};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MPADS; i++) m_mode[i] <= 2'd0;
      m_en   <= '0;
      m_wen  <= '1;
      m_stat <= '0;
      m_lout <= '0;
      m_loe  <= '0;
    end else begin
      for (int i = 0; i < NUM_MPADS; i++) begin
        if (m_acc && idx == IDX_W'(i)) begin
          if (rg == RG_MODE && m_wen[i]) m_mode[i] <= reg_wdata[1:0];
          if (rg == RG_ARM && m_wen[i])  m_en[i]   <= reg_wdata[0];
          if (rg == RG_WEN && !reg_wdata[0]) m_wen[i] <= 1'b0;
        end
        if (m_acc && rg == RG_STAT && idx == IDX_W'(i / 32) && !reg_wdata[i % 32])
          m_stat[i] <= 1'b0;
        if (sleep_req && m_en[i]) begin
          m_stat[i] <= 1'b1;
          if (!m_stat[i]) begin
            m_lout[i] <= mp_fn_out[i];
            m_loe[i]  <= mp_fn_oe[i];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DPADS; i++) d_mode[i] <= 2'd0;
      d_en   <= '0;
      d_wen  <= '1;
      d_stat <= '0;
      d_lout <= '0;
      d_loe  <= '0;
    end else begin
      for (int i = 0; i < NUM_DPADS; i++) begin
        if (d_acc && idx == IDX_W'(i)) begin
          if (rg == RG_MODE && d_wen[i]) d_mode[i] <= reg_wdata[1:0];
          if (rg == RG_ARM && d_wen[i])  d_en[i]   <= reg_wdata[0];
          if (rg == RG_WEN && !reg_wdata[0]) d_wen[i] <= 1'b0;
        end
        if (d_acc && rg == RG_STAT && idx == IDX_W'(i / 32) && !reg_wdata[i % 32])
          d_stat[i] <= 1'b0;
        if (sleep_req && d_en[i]) begin
          d_stat[i] <= 1'b1;
          if (!d_stat[i]) begin
            d_lout[i] <= dp_fn_out[i];
            d_loe[i]  <= dp_fn_oe[i];
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_MPADS; i++)
      {mp_pad_oe[i], mp_pad_out[i]} = m_stat[i] ? drive_of(m_mode[i], m_lout[i], m_loe[i])
                                                : {mp_fn_oe[i], mp_fn_out[i]};
    for (int i = 0; i < NUM_DPADS; i++)
      {dp_pad_oe[i], dp_pad_out[i]} = d_stat[i] ? drive_of(d_mode[i], d_lout[i], d_loe[i])
                                                : {dp_fn_oe[i], dp_fn_out[i]};
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_MPADS; i++) begin
      if (!grp && idx == IDX_W'(i)) begin
        case (rg)
          RG_MODE: reg_rdata[1:0] = m_mode[i];
          RG_ARM:  reg_rdata[0]   = m_en[i];
          RG_WEN:  reg_rdata[0]   = m_wen[i];
          default: ;
        endcase
      end
      if (!grp && rg == RG_STAT && idx == IDX_W'(i / 32)) reg_rdata[i % 32] = m_stat[i];
    end
    for (int i = 0; i < NUM_DPADS; i++) begin
      if (grp && idx == IDX_W'(i)) begin
        case (rg)
          RG_MODE: reg_rdata[1:0] = d_mode[i];
          RG_ARM:  reg_rdata[0]   = d_en[i];
          RG_WEN:  reg_rdata[0]   = d_wen[i];
          default: ;
        endcase
      end
      if (grp && rg == RG_STAT && idx == IDX_W'(i / 32)) reg_rdata[i % 32] = d_stat[i];
    end
  end

endmodule

// File: rtl/pad_sleep_ctrl_chk.sv
module pad_sleep_ctrl_chk #(
  parameter int NUM_MPADS = 40,
  parameter int NUM_DPADS = 12,
  parameter int IDX_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sleep_req,
  input logic                 reg_wr,
  input logic [IDX_W+2:0]     reg_addr,
  input logic [1:0]           m_mode [NUM_MPADS],
  input logic [NUM_MPADS-1:0] m_en,
  input logic [NUM_MPADS-1:0] m_wen,
  input logic [NUM_MPADS-1:0] m_stat,
  input logic [NUM_MPADS-1:0] mp_pad_oe,
  input logic [NUM_DPADS-1:0] d_wen
);

  logic m_stat_wr;
  assign m_stat_wr = reg_wr && !reg_addr[IDX_W+2] && reg_addr[IDX_W+1:IDX_W] == 2'd3;

  for (genvar k = 0; k < NUM_MPADS; k++) begin : g_m
    AST_SLEEP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req && m_en[k] |=> m_stat[k]); // R3
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !m_stat[k] && !sleep_req |=> !m_stat[k]); // R3
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      m_stat[k] && !m_stat_wr |=> m_stat[k]); // R4
    AST_HIZ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      m_stat[k] && m_mode[k] == 2'd2 |-> !mp_pad_oe[k]); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !m_wen[k] |=> !m_wen[k]); // R6
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !m_wen[k] |=> $stable(m_mode[k]) && $stable(m_en[k])); // R7
  end

  for (genvar k = 0; k < NUM_DPADS; k++) begin : g_d
    AST_DLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !d_wen[k] |=> !d_wen[k]); // R6
  end

endmodule

bind pad_sleep_ctrl pad_sleep_ctrl_chk #(
  .NUM_MPADS(NUM_MPADS), .NUM_DPADS(NUM_DPADS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .m_mode(m_mode), .m_en(m_en), .m_wen(m_wen), .m_stat(m_stat),
  .mp_pad_oe(mp_pad_oe), .d_wen(d_wen)
);

// File: tb/tb_pad_sleep_ctrl.sv
module tb_pad_sleep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 40;
  localparam int ND = 12;
  localparam int IW = 6;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          sleep_req = 0;
  logic          reg_wr = 0;
  logic [IW+2:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NM-1:0] mfo = '0, mfoe = '0, mpo, mpoe;
  logic [ND-1:0] dfo = '0, dfoe = '0, dpo, dpoe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] e_mode [2][64];
  bit e_en [2][64], e_wen [2][64], e_stat [2][64], e_lo [2][64], e_loe [2][64];

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_sleep_ctrl #(.NUM_MPADS(NM), .NUM_DPADS(ND), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mp_fn_out(mfo), .mp_fn_oe(mfoe), .dp_fn_out(dfo), .dp_fn_oe(dfoe),
    .mp_pad_out(mpo), .mp_pad_oe(mpoe), .dp_pad_out(dpo), .dp_pad_oe(dpoe));

  function automatic int npad(input int g);
    return g ? ND : NM;
  endfunction

  function automatic bit fn_o(input int g, input int p);
    return g ? dfo[p] : mfo[p];
  endfunction

  function automatic bit fn_e(input int g, input int p);
    return g ? dfoe[p] : mfoe[p];
  endfunction

  task automatic model_reset();
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 64; p++) begin
        e_mode[g][p] = 0; e_en[g][p] = 0; e_wen[g][p] = 1;
        e_stat[g][p] = 0; e_lo[g][p] = 0; e_loe[g][p] = 0;
      end
  endtask

  task automatic model_edge(input bit wr, input int g, input int rg, input int idx,
                            input logic [31:0] d, input bit slp);
    for (int gg = 0; gg < 2; gg++)
      for (int p = 0; p < npad(gg); p++) begin
        bit old_st = e_stat[gg][p];
        bit old_en = e_en[gg][p];
        if (wr && gg == g && idx == p) begin
          if (rg == 0 && e_wen[gg][p]) e_mode[gg][p] = d[1:0];
          if (rg == 1 && e_wen[gg][p]) e_en[gg][p] = d[0];
          if (rg == 2 && !d[0]) e_wen[gg][p] = 0;
        end
        if (wr && gg == g && rg == 3 && idx == p / 32 && !d[p % 32]) e_stat[gg][p] = 0;
        if (slp && old_en) begin
          if (!old_st) begin e_lo[gg][p] = fn_o(gg, p); e_loe[gg][p] = fn_e(gg, p); end
          e_stat[gg][p] = 1;
        end
      end
  endtask

  task automatic cyc(input bit wr, input int g, input int rg, input int idx,
                     input logic [31:0] d, input bit slp);
    reg_wr = wr;
    reg_addr = {g[0], rg[1:0], idx[IW-1:0]};
    reg_wdata = d;
    sleep_req = slp;
    model_edge(wr, g, rg, idx, d, slp);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0;
    sleep_req = 0;
  endtask

  function automatic logic [31:0] exp_rd(input int g, input int rg, input int idx);
    logic [31:0] r = '0;
    for (int p = 0; p < npad(g); p++) begin
      if (idx == p) begin
        if (rg == 0) r[1:0] = e_mode[g][p];
        if (rg == 1) r[0] = e_en[g][p];
        if (rg == 2) r[0] = e_wen[g][p];
      end
      if (rg == 3 && idx == p / 32) r[p % 32] = e_stat[g][p];
    end
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int g = 0; g < 2; g++)
      for (int rg = 0; rg < 4; rg++)
        for (int idx = 0; idx < 64; idx++) begin
          reg_addr = {g[0], rg[1:0], idx[IW-1:0]};
          #1;
          check(tag, $sformatf("read g%0d rg%0d idx%0d", g, rg, idx), reg_rdata, exp_rd(g, rg, idx));
        end
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < npad(g); p++) begin
        logic [1:0] exp, act;
        if (!e_stat[g][p]) exp = {fn_e(g, p), fn_o(g, p)};
        else case (e_mode[g][p])
          2'd0: exp = 2'b10;
          2'd1: exp = 2'b11;
          2'd2: exp = 2'b00;
          default: exp = {e_loe[g][p], e_lo[g][p]};
        endcase
        act = g ? {dpoe[p], dpo[p]} : {mpoe[p], mpo[p]};
        check(tag, $sformatf("pad g%0d p%0d {oe,out}", g, p), 32'(act), 32'(exp));
      end
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check_all("R1");

    mfo = 40'hA5_3C96_0F1E; mfoe = 40'h5A_FF00_C3A5; dfo = 12'hB6D; dfoe = 12'h3C9;
    #1 check_all("R5");

    // R9: distinct configuration per group
    for (int p = 0; p < NM; p++) begin
      cyc(1, 0, 0, p, 32'(p % 4), 0);
      cyc(1, 0, 1, p, (p % 3 != 2) ? 32'd1 : 32'd0, 0);
    end
    for (int p = 0; p < ND; p++) begin
      cyc(1, 1, 0, p, 32'((p + 1) % 4), 0);
      cyc(1, 1, 1, p, (p % 2 == 0) ? 32'd1 : 32'd0, 0);
    end
    check_all("R9");

    cyc(0, 0, 0, 0, 0, 1);
    mfo = 40'h13_57_9BDF_02; mfoe = 40'hF0_0F_A55A_3C; dfo = 12'h5A3; dfoe = 12'hC3C;
    #1 check_all("R2 R3");

    // R4: clear even pads in both words, odd written 1 stay
    cyc(1, 0, 3, 0, 32'hAAAA_AAAA, 0);
    cyc(1, 0, 3, 1, 32'hAAAA_AAAA, 0);
    cyc(1, 1, 3, 0, 32'hAAAA_AAAA, 0);
    check_all("R4");

    // R3: second entry, odd pads keep first capture
    mfo = ~mfo; mfoe = ~mfoe; dfo = ~dfo; dfoe = ~dfoe;
    cyc(0, 0, 0, 0, 0, 1);
    mfo = 40'h0F_F0F0_0F0F; dfo = 12'h0F0;
    #1 check_all("R3");

    // R10: clear and sleep in same cycle
    cyc(1, 0, 3, 0, 32'h0, 1);
    check_all("R10");

    for (int w = 0; w < 2; w++) cyc(1, 0, 3, w, 32'h0, 0);
    cyc(1, 1, 3, 0, 32'h0, 0);
    check_all("R5");

    // R6 R7: lock and try to modify
    cyc(1, 0, 2, 5, 32'hFFFF_FFFE, 0);
    cyc(1, 0, 2, 33, 32'h0, 0);
    cyc(1, 1, 2, 3, 32'h0, 0);
    cyc(1, 0, 2, 5, 32'h1, 0);
    cyc(1, 1, 2, 3, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 0, 5, 32'h2, 0);
    cyc(1, 0, 1, 5, 32'h0, 0);
    cyc(1, 0, 0, 33, 32'h3, 0);
    cyc(1, 1, 0, 3, 32'h2, 0);
    cyc(1, 1, 1, 3, 32'h1, 0);
    cyc(1, 0, 0, 6, 32'h1, 0);
    check_all("R6 R7");

    // R8: out-of-range accesses
    for (int idx = NM; idx < 64; idx++)
      for (int rg = 0; rg < 3; rg++) begin
        cyc(1, 0, rg, idx, 32'hFFFF_FFFF, 0);
        cyc(1, 0, rg, idx, 32'h0, 0);
      end
    for (int idx = ND; idx < 64; idx++) cyc(1, 1, 1, idx, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 3, 2, 32'h0, 0);
    cyc(1, 1, 3, 1, 32'h0, 0);
    check_all("R8");

    // R3: disarm then sleep
    cyc(1, 0, 1, 0, 32'h0, 0);
    cyc(1, 0, 1, 1, 32'h0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    check_all("R3");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end
endmodule